// File: doc/BRIEF.md
# Abort-Safe GPIO Direction Bank

This block is a bank of general-purpose pins with two host-writable registers. One holds the direction of each pin, the other the level each output pin drives. The block produces the output-enable and output-data vectors for the pad ring, and it brings the pin levels back in through a two-flop synchroniser.

A safety abort input overrides the direction register. While the abort is high, every output enable is low, so the pads float and board pull resistors set a safe level. The direction register itself is left as it is. A host write made during the abort updates only the stored value and never turns a pin into an output. When the abort drops, the stored directions drive the pins again, and software does not have to rewrite anything.

Top module: `gpio_abort_bank`

## Requirements
- R1: After reset, `oe_o`, `dout_o` and `dir_cfg_o` are all zero, so every pin is an input.
- R2: A write with `wr_en_i`=1 and `wr_sel_i`=0 (direction) stores `wr_data_i` into `dir_cfg_o` at the next clock. While abort is low, `oe_o` equals that value one clock later (bit set = pin drives).
- R3: A write with `wr_sel_i`=1 (data) stores `wr_data_i` into `dout_o` at the next clock. It leaves the direction register unchanged.
- R4: In any cycle in which `abort_i` is high, `oe_o` is all zero, combinationally from `abort_i`.
- R5: A direction write while `abort_i` is high never makes any bit of `oe_o` high in any cycle of the abort.
- R6: A direction write made during the abort is stored and visible on `dir_cfg_o` at the next clock.
- R7: One clock after `abort_i` falls, `oe_o` equals the stored direction, with no host write.
- R8: `din_o` equals `pad_in_i` as it was two clocks earlier.
- R9: The abort has no effect on `dout_o`. Data writes made during the abort are applied at once.
- R10: The bank has 14 pins by default, set by a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = direction register, 1 = data register |
| wr_data_i | input | 14 | Write data |
| abort_i | input | 1 | Safety abort, forces all pins to input |
| pad_in_i | input | 14 | Raw pin levels |
| oe_o | output | 14 | Effective output enables |
| dout_o | output | 14 | Output data levels |
| dir_cfg_o | output | 14 | Stored direction register readback |
| din_o | output | 14 | Synchronised pin levels |

## Verification
The assertions check on every cycle that an abort holds the enables at zero and that both registers take the written word. They also check that, outside the abort, the enables follow the stored direction one clock later, and that the input path has a two-clock latency. Only the bench scenarios can show the whole sequence: a write inside an abort, the register readback during the abort, and the restore after release. The bench also covers the data register's indifference to the abort across sweeps of walking and mixed patterns.

// File: rtl/gpio_abort_pkg.sv
package gpio_abort_pkg;
  typedef enum logic {
    SEL_DIR  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_abort_pkg::*;
#(
  parameter int unsigned WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  reg_sel_e         wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] dir_q_o,
  output logic [WIDTH-1:0] data_q_o
);
  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] data_q, data_d;
  logic             dir_ce, data_ce;

  always_comb begin
    dir_ce  = wr_en_i && (wr_sel_i == SEL_DIR);
    data_ce = wr_en_i && (wr_sel_i == SEL_DATA);
    dir_d   = dir_ce  ? wr_data_i : dir_q;
    data_d  = data_ce ? wr_data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end

  assign dir_q_o  = dir_q;
  assign data_q_o = data_q;

  // R2 R6: direction write lands next clock, abort or not
  a_r6_dir_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_DIR) |=> dir_q_o == $past(wr_data_i));
  // R3: data write lands, direction untouched
  a_r3_data_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_DATA) |=> (data_q_o == $past(wr_data_i)) && $stable(dir_q_o));
endmodule

// File: rtl/gpio_dir_gate.sv
module gpio_dir_gate #(
  parameter int unsigned WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic [WIDTH-1:0] dir_cfg_i,
  output logic [WIDTH-1:0] oe_o
);
  logic [WIDTH-1:0] oe_q, oe_d;
  logic [WIDTH-1:0] abort_mask;

  always_comb begin
    abort_mask = {WIDTH{~abort_i}};
    oe_d       = dir_cfg_i & abort_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= '0;
    else        oe_q <= oe_d;
  end

  // Registered enable, plus an immediate cut while abort is high
  assign oe_o = oe_q & abort_mask;

  // R7 R2: outside an abort, enables trail the stored direction by one clock
  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_i && $past(!abort_i)) |-> oe_o == $past(dir_cfg_i));
  // R5: no enable can rise across an abort-held cycle
  a_r5_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort_i) |-> oe_o == '0 || !abort_i);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 14,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [1:0]       warm_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pad_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R8: two-clock latency from pad to synchronised value
  a_r8_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && STAGES == 2) |-> sync_o == $past(pad_i, 2));
endmodule

// File: rtl/gpio_abort_bank.sv
module gpio_abort_bank
  import gpio_abort_pkg::*;
#(
  parameter int unsigned NUM_PINS = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  input  logic                abort_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [NUM_PINS-1:0] dir_cfg_o,
  output logic [NUM_PINS-1:0] din_o
);
  localparam int unsigned SYNC_STAGES = 2;

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] dir_q, data_q;

  assign sel = reg_sel_e'(wr_sel_i);

  gpio_cfg_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .dir_q_o   (dir_q),
    .data_q_o  (data_q)
  );

  gpio_dir_gate #(.WIDTH(NUM_PINS)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_i   (abort_i),
    .dir_cfg_i (dir_q),
    .oe_o      (oe_o)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_i  (pad_in_i),
    .sync_o (din_o)
  );

  assign dout_o    = data_q;
  assign dir_cfg_o = dir_q;

  // R4: abort holds every enable low
  a_r4_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> oe_o == '0);
  // R9: abort alone never moves the data register
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !$past(wr_en_i)) |-> $stable(dout_o) || !$past(abort_i));
endmodule

// File: tb/gpio_abort_bank_test.sv
module gpio_abort_bank_test;
  localparam int N = 14;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, wr_sel, abort;
  logic [N-1:0] wr_data, pad;
  logic [N-1:0] oe, dout, cfg, din;
  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  gpio_abort_bank #(.NUM_PINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .abort_i(abort), .pad_in_i(pad),
    .oe_o(oe), .dout_o(dout), .dir_cfg_o(cfg), .din_o(din)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [N-1:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [N-1:0] pat(input int i);
    logic [N-1:0] v;
    v = '0;
    if (i < N) v[i] = 1'b1;
    else v = N'((i * 32'h2f3b) ^ (i << 3));
    return v;
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; abort = 1'b0;
    wr_data = '0; pad = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", oe, '0);
    check("R1 dout", dout, '0);
    check("R1 cfg", cfg, '0);
    check("R10 width", N'($bits(oe)), N'(14));

    // R2 R3 sweep over walking ones and mixed words
    for (int i = 0; i < N + 10; i++) begin
      logic [N-1:0] d, v;
      d = pat(i); v = ~pat(i + 3);
      do_write(1'b0, d);
      check("R2 cfg", cfg, d);
      @(negedge clk);
      check("R2 oe", oe, d);
      do_write(1'b1, v);
      check("R3 dout", dout, v);
      check("R3 cfg kept", cfg, d);
    end

    // Abort scenarios
    for (int i = 0; i < N + 6; i++) begin
      logic [N-1:0] d0, d1, v;
      d0 = pat(i + 5) | 14'h0001; d1 = ~pat(i); v = pat(i + 7);
      do_write(1'b0, d0);
      @(negedge clk);
      check("R2 pre-abort oe", oe, d0);
      abort = 1'b1;
      #1 check("R4 immediate", oe, '0);
      @(negedge clk);
      check("R4 held", oe, '0);
      // R5 R6: direction write during abort
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = d1;
      @(negedge clk);
      wr_en = 1'b0;
      check("R5 no drive", oe, '0);
      check("R6 stored", cfg, d1);
      @(negedge clk);
      check("R5 still off", oe, '0);
      // R9: data during abort
      do_write(1'b1, v);
      check("R9 data in abort", dout, v);
      check("R5 after data", oe, '0);
      abort = 1'b0;
      @(negedge clk);
      check("R7 restore", oe, d1);
      check("R9 data kept", dout, v);
    end

    // R8 synchroniser latency
    for (int i = 0; i < N + 10; i++) begin
      logic [N-1:0] p;
      p = pat(i) ^ N'(i * 97);
      @(negedge clk);
      pad = p;
      @(negedge clk);
      pad = ~p;
      @(negedge clk);
      check("R8 sync", din, p);
      @(negedge clk);
      check("R8 sync2", din, ~p);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule